// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. Every clock it samples one command: an address, a read/write select, an advance/load strobe, three chip-enable inputs, a clock enable and per-byte write enables. The data for a command uses the bus two edges later. This holds for reads and for writes. Because both directions share the same distance, a controller can issue reads and writes in any mix on consecutive clocks and the data bus never needs an idle cycle to turn around.

A load command starts an access at a new address. The following advance commands continue it as a burst of up to four beats. The burst steps the two lowest address bits in linear order and wraps within a group of four. A load while the chip is not selected is a deselect: it ends the burst and floats the bus in its slot. The data bus is modelled as three signals: an input from the bus, an output to the bus, and an output-drive qualifier. This lets the block sit inside a larger simulation or netlist without internal tristates. Data width (lanes times lane width) and array depth (from the address width) are parameters.

Top module: `zbt_sram`

## Requirements
- R1: The chip counts as selected only when `en_a_n`=0, `en_b_n`=0 and `en_c`=1. A load (`adv_not_ld`=0) with `clk_en_n`=0 while selected starts an access at `cmd_addr`. A load under any other enable combination is a deselect, and a write attempted that way changes no memory word.
- R2: A read command sampled at edge k has its data on `bus_out`, with `bus_drive`=1, during the clock cycle that ends at edge k+2. `rd_not_wr`=1 selects read.
- R3: A write command (`rd_not_wr`=0) sampled at edge k stores the `bus_in` value sampled at edge k+2. During that slot `bus_drive` is 0.
- R4: Byte lane i is bits [8i+7:8i] of the data word. A lane is written only when its `lane_wr_n` bit, sampled with that beat's command, is 0. A lane whose bit is 1 keeps its stored value.
- R5: An advance command (`adv_not_ld`=1) after a load or after another advance repeats the loaded operation at the next burst address, and `cmd_addr` is ignored. The two low address bits count up by one modulo 4, and the upper bits stay fixed. So a burst loaded at 0x32 visits 0x32, 0x33, 0x30, 0x31.
- R6: A deselect ends any burst in progress, and `bus_drive` is 0 in its slot. An advance that follows a deselect is a no-operation: its slot is not driven and it writes nothing.
- R7: Reads and writes issued on consecutive clocks are all serviced with no idle bus slot. A read issued right after a write to the same address returns the newly written data.
- R8: `out_en_n`=1 forces `bus_drive` to 0. It has no effect on which commands are accepted, nor on how a burst proceeds.
- R9: While `clk_en_n`=1, the edge has no effect. Commands are not sampled, the burst address does not move, no memory word is written, and the bus drive state is held.
- R10: After reset `bus_drive` is 0 and no burst is active. Advance commands issued right after reset are no-operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_addr | input | ADDR_W | Word address for load commands |
| rd_not_wr | input | 1 | 1 = read, 0 = write, sampled on load |
| adv_not_ld | input | 1 | 0 = load/deselect, 1 = advance burst |
| en_a_n | input | 1 | Active-low chip enable A |
| en_b_n | input | 1 | Active-low chip enable B |
| en_c | input | 1 | Active-high chip enable |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| lane_wr_n | input | LANES | Per-lane active-low write enables |
| out_en_n | input | 1 | Active-low output enable for read drivers |
| bus_in | input | LANES*LANE_W | Data arriving from the shared bus |
| bus_out | output | LANES*LANE_W | Read data offered to the shared bus |
| bus_drive | output | 1 | 1 when the block drives the bus |

## Verification
The bench goes after these cases:
- A read issued on the clock right after a write to the same address. A design without write-to-read forwarding would return the stale word.
- Bursts that cross the wrap point of their group of four. A design that carried into the upper address bits would read or write the neighbouring group.
- Advances that follow a deselect, and write attempts under each of the three invalid enable patterns. A design that kept the burst alive or mis-decoded an enable would corrupt memory words that are read back later.
- Clock-enable stalls that carry a load-write and an advance. A design that let either through would move the burst address, which shows up as a wrong next beat, or would store junk over data that is read back afterwards.

// File: rtl/zbt_pkg.sv
// Package: shared types and helpers for the pipelined synchronous SRAM.
// Assumes burst groups of exactly four words (two low address bits).
package zbt_pkg;

    // Operation carried by a command through the pipeline.
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Next low-address pair in a linear burst, wrapping modulo four.
    function automatic logic [1:0] burst_step(input logic [1:0] lo);
        return lo + 2'd1;
    endfunction

endpackage

// File: rtl/zbt_ctrl.sv
// Module: command decode and burst address stage (pipeline stage 1).
// Decodes chip select and the load/advance strobe, and keeps the current
// burst address. It registers one command per enabled edge. s1_valid doubles
// as the "burst active" flag: it is set by a load or an advance and cleared
// by a deselect or a no-operation.
// Assumes ADDR_W >= 2.
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              rd_not_wr,
    input  logic              adv_not_ld,
    input  logic              en_a_n,
    input  logic              en_b_n,
    input  logic              en_c,
    input  logic [LANES-1:0]  lane_wr_n,
    output logic              chip_sel,
    output logic              s1_valid,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_lane_n
);

    // Chip is selected only for the single valid enable combination.
    assign chip_sel = !en_a_n && !en_b_n && en_c;

    // Register the decoded command and advance the burst address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_op     <= OP_READ;
            s1_addr   <= '0;
            s1_lane_n <= '1;
        end else if (step) begin
            s1_lane_n <= lane_wr_n;
            if (!adv_not_ld) begin
                if (chip_sel) begin
                    s1_valid <= 1'b1;
                    s1_op    <= rd_not_wr ? OP_READ : OP_WRITE;
                    s1_addr  <= cmd_addr;
                end else begin
                    s1_valid <= 1'b0;
                end
            end else if (s1_valid) begin
                s1_addr <= {s1_addr[ADDR_W-1:2], burst_step(s1_addr[1:0])};
            end else begin
                s1_valid <= 1'b0;
            end
        end
    end

    // R1: a selected load captures the presented address.
    assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_not_ld && chip_sel) |=> (s1_valid && s1_addr == $past(cmd_addr)));

    // R5: an advance steps the low bits modulo four and keeps the upper bits.
    assert_burst_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && adv_not_ld && s1_valid) |=>
        (s1_valid && s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1 &&
         s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

    // R9: a disabled edge leaves the stage untouched.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(s1_valid) && $stable(s1_addr) && $stable(s1_op) &&
                   $stable(s1_lane_n)));

endmodule

// File: rtl/zbt_pipe.sv
// Module: second pipeline stage that aligns commands with their bus slot.
// A command in stage 2 owns the bus cycle that ends at the next enabled
// edge. Writes commit on that edge. Reads are fetched one edge earlier,
// from stage 1, so their data is on the bus for the whole slot.
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              s1_valid,
    input  op_e               s1_op,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [LANES-1:0]  s1_lane_n,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_lane_n,
    output logic              rd_load,
    output logic              rd_slot
);

    logic              s2_valid;
    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;

    // Move the stage-1 command into the slot-owning stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_op     <= OP_READ;
            s2_addr   <= '0;
            s2_lane_n <= '1;
        end else if (step) begin
            s2_valid  <= s1_valid;
            s2_op     <= s1_op;
            s2_addr   <= s1_addr;
            s2_lane_n <= s1_lane_n;
        end
    end

    // Strobes for the array: commit the stage-2 write, fetch the stage-1 read.
    assign wr_commit = step && s2_valid && (s2_op == OP_WRITE);
    assign wr_addr   = s2_addr;
    assign wr_lane_n = s2_lane_n;
    assign rd_load   = step && s1_valid && (s1_op == OP_READ);
    assign rd_slot   = s2_valid && (s2_op == OP_READ);

endmodule

// File: rtl/zbt_array.sv
// Module: byte-lane storage array with a registered read port.
// There is one storage column per lane. A write and a read can happen on the
// same edge. When they hit the same address, each enabled lane forwards the
// incoming write data so the read sees the new value.
// Assumes the memory contents need no reset.
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lane_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic same_word;
    assign same_word = wr_commit && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] q;
        logic              hit;

        assign hit = same_word && !wr_lane_n[g];

        // Store this lane when the slot's write enables it.
        always_ff @(posedge clk) begin
            if (wr_commit && !wr_lane_n[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Fetch this lane for a read, forwarding a same-edge write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (rd_load) begin
                q <= hit ? wr_data[g*LANE_W +: LANE_W] : cells[rd_addr];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = q;
    end

    // R7: a full-word write and a read of the same word on one edge deliver the new data.
    assert_forward_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && same_word && wr_lane_n == '0) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/zbt_sram.sv
// Module: top of the pipelined zero-turnaround synchronous SRAM.
// Every register is gated by the active-low clock enable. Data for any
// command uses the bus slot two enabled edges after that command.
// The bus is split into an input, an output and a drive qualifier.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              rd_not_wr,
    input  logic              adv_not_ld,
    input  logic              en_a_n,
    input  logic              en_b_n,
    input  logic              en_c,
    input  logic              clk_en_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive
);

    logic              step;
    logic              chip_sel;
    logic              s1_valid;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_lane_n;
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_lane_n;
    logic              rd_load;
    logic              rd_slot;

    assign step = !clk_en_n;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .cmd_addr   (cmd_addr),
        .rd_not_wr  (rd_not_wr),
        .adv_not_ld (adv_not_ld),
        .en_a_n     (en_a_n),
        .en_b_n     (en_b_n),
        .en_c       (en_c),
        .lane_wr_n  (lane_wr_n),
        .chip_sel   (chip_sel),
        .s1_valid   (s1_valid),
        .s1_op      (s1_op),
        .s1_addr    (s1_addr),
        .s1_lane_n  (s1_lane_n)
    );

    zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .s1_valid  (s1_valid),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_lane_n (s1_lane_n),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_lane_n (wr_lane_n),
        .rd_load   (rd_load),
        .rd_slot   (rd_slot)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_addr   (wr_addr),
        .wr_lane_n (wr_lane_n),
        .wr_data   (bus_in),
        .rd_load   (rd_load),
        .rd_addr   (s1_addr),
        .rd_data   (bus_out)
    );

    // Drive the bus only in a read slot and only while output enable is low.
    assign bus_drive = rd_slot && !out_en_n;

    // R2: a selected read load two enabled edges back owns a driven read slot.
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(step) &&
         $past(step && !adv_not_ld && chip_sel && rd_not_wr, 2)) |-> rd_slot);

    // R6: a deselect two enabled edges back leaves its slot undriven.
    assert_desel_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(step) &&
         $past(step && !adv_not_ld && !chip_sel, 2)) |-> !rd_slot);

endmodule

// File: tb/zbt_sram_bench.sv
// Directed bench: one task per scenario. Inputs change on the falling edge.
// After issue k+1 returns, the bus shows the slot of command k, and the data
// passed to issue k+2 is the write data for command k.
module zbt_sram_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic LD = 1'b0, ADV = 1'b1, RD = 1'b1, WR = 1'b0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] cmd_addr;
    logic          rd_not_wr, adv_not_ld, en_a_n, en_b_n, en_c, clk_en_n, out_en_n;
    logic [3:0]    lane_wr_n;
    logic [DW-1:0] bus_in, bus_out;
    logic          bus_drive;
    int checks = 0;
    int failures = 0;

    zbt_sram u_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .rd_not_wr(rd_not_wr),
        .adv_not_ld(adv_not_ld), .en_a_n(en_a_n), .en_b_n(en_b_n), .en_c(en_c),
        .clk_en_n(clk_en_n), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive)
    );

    always #10 clk = ~clk;

    task automatic issue_raw(input logic adv, input logic rw, input logic [2:0] en,
                             input logic [AW-1:0] a, input logic [3:0] bw,
                             input logic [DW-1:0] d);
        adv_not_ld = adv; rd_not_wr = rw;
        en_a_n = en[2]; en_b_n = en[1]; en_c = en[0];
        cmd_addr = a; lane_wr_n = bw; bus_in = d;
        @(negedge clk);
    endtask

    task automatic ld_wr(input logic [AW-1:0] a, input logic [3:0] bw, input logic [DW-1:0] d);
        issue_raw(LD, WR, 3'b001, a, bw, d);
    endtask
    task automatic ld_rd(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue_raw(LD, RD, 3'b001, a, 4'hF, d);
    endtask
    task automatic cont(input logic [AW-1:0] junk, input logic [DW-1:0] d);
        issue_raw(ADV, ~rd_not_wr, 3'b100, junk, 4'h0, d);
    endtask
    task automatic desel(input logic [DW-1:0] d);
        issue_raw(LD, RD, 3'b101, 8'hEE, 4'hF, d);
    endtask

    task automatic chk(input logic exp_drv, input logic [DW-1:0] exp_d, input string tag);
        checks++;
        if (bus_drive !== exp_drv || (exp_drv && bus_out !== exp_d)) begin
            failures++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     tag, bus_drive, bus_out, exp_drv, exp_d);
        end
    endtask

    task automatic t_reset();
        chk(1'b0, '0, "R10 idle after reset");
        issue_raw(ADV, RD, 3'b001, 8'h05, 4'h0, '0);
        issue_raw(ADV, WR, 3'b001, 8'h06, 4'h0, '0);
        chk(1'b0, '0, "R10 advance after reset is nop");
        desel('0);
        chk(1'b0, '0, "R10 second advance after reset is nop");
        desel('0);
    endtask

    task automatic t_basic();
        ld_wr(8'h10, 4'h0, '0);
        desel('0);
        chk(1'b0, '0, "R3 write slot not driven");
        desel(32'hDEADBEEF);
        ld_rd(8'h10, '0);
        desel('0);
        chk(1'b1, 32'hDEADBEEF, "R2 read after write");
        desel('0);
        desel('0);
    endtask

    task automatic t_lanes();
        ld_wr(8'h20, 4'h0, '0); desel('0); desel(32'h11111111);
        ld_wr(8'h20, 4'b0101, '0); desel('0); desel(32'hAABBCCDD);
        ld_rd(8'h20, '0); desel('0);
        chk(1'b1, 32'hAA11CC11, "R4 masked lanes kept");
        desel('0); desel('0);
    endtask

    task automatic t_burst();
        ld_wr(8'h32, 4'h0, '0);
        issue_raw(ADV, RD, 3'b100, 8'hFF, 4'h0, '0);
        issue_raw(ADV, RD, 3'b100, 8'h00, 4'h0, 32'hB0000032);
        issue_raw(ADV, RD, 3'b100, 8'h77, 4'h0, 32'hB0000033);
        desel(32'hB0000030);
        desel(32'hB0000031);
        ld_rd(8'h30, '0);
        issue_raw(ADV, WR, 3'b011, 8'hAB, 4'h0, '0);
        chk(1'b1, 32'hB0000030, "R5 burst beat 0");
        issue_raw(ADV, WR, 3'b011, 8'h12, 4'h0, '0);
        chk(1'b1, 32'hB0000031, "R5 burst beat 1");
        issue_raw(ADV, WR, 3'b011, 8'h34, 4'h0, '0);
        chk(1'b1, 32'hB0000032, "R5 burst beat 2");
        desel('0);
        chk(1'b1, 32'hB0000033, "R5 burst beat 3 wraps in group");
        desel('0);
        chk(1'b0, '0, "R6 slot after burst end undriven");
        desel('0);
    endtask

    task automatic t_interleave();
        ld_wr(8'h40, 4'h0, '0);
        ld_rd(8'h40, '0);
        chk(1'b0, '0, "R7 write slot in mix");
        ld_wr(8'h41, 4'h0, 32'hA0A0A0A0);
        chk(1'b1, 32'hA0A0A0A0, "R7 read just after write forwards");
        ld_rd(8'h41, 32'h0BAD0BAD);
        chk(1'b0, '0, "R7 second write slot");
        desel(32'hB1B1B1B1);
        chk(1'b1, 32'hB1B1B1B1, "R7 second read forwards");
        desel('0);
        chk(1'b0, '0, "R7 bus idle after mix");
        desel('0);
    endtask

    task automatic t_deselect();
        ld_wr(8'h51, 4'h0, '0); desel('0); desel(32'h51515151);
        ld_wr(8'h50, 4'h0, '0);
        desel('0);
        issue_raw(ADV, WR, 3'b001, 8'h51, 4'h0, 32'h50505050);
        chk(1'b0, '0, "R6 deselect slot undriven");
        issue_raw(ADV, WR, 3'b001, 8'h52, 4'h0, 32'hFFFFFFFF);
        chk(1'b0, '0, "R6 advance after deselect undriven");
        desel(32'hFFFFFFFF);
        chk(1'b0, '0, "R6 second advance undriven");
        desel(32'hFFFFFFFF);
        ld_rd(8'h50, '0);
        ld_rd(8'h51, '0);
        chk(1'b1, 32'h50505050, "R6 loaded write kept");
        desel('0);
        chk(1'b1, 32'h51515151, "R6 advance after deselect wrote nothing");
        desel('0); desel('0);
        ld_rd(8'h30, '0);
        desel('0);
        chk(1'b1, 32'hB0000030, "R6 read before deselect");
        issue_raw(ADV, RD, 3'b001, 8'h31, 4'hF, '0);
        chk(1'b0, '0, "R6 read burst stopped");
        desel('0);
        chk(1'b0, '0, "R6 advance after read deselect is nop");
        desel('0);
    endtask

    task automatic t_out_enable();
        out_en_n = 1'b1;
        ld_rd(8'h30, '0);
        issue_raw(ADV, WR, 3'b111, 8'h00, 4'h0, '0);
        chk(1'b0, '0, "R8 output enable high blocks drive");
        out_en_n = 1'b0;
        issue_raw(ADV, WR, 3'b111, 8'h00, 4'h0, '0);
        chk(1'b1, 32'hB0000031, "R8 burst kept running under output enable");
        desel('0); desel('0);
    endtask

    task automatic t_enables();
        ld_wr(8'h60, 4'h0, '0); desel('0); desel(32'h60606060);
        for (int i = 0; i < 3; i++) begin
            logic [2:0] bad;
            bad = (i == 0) ? 3'b101 : (i == 1) ? 3'b011 : 3'b000;
            issue_raw(LD, WR, bad, 8'h60, 4'h0, '0);
            desel('0);
            chk(1'b0, '0, "R1 unselected load slot undriven");
            desel(32'h0BADBAD0);
        end
        ld_rd(8'h60, '0); desel('0);
        chk(1'b1, 32'h60606060, "R1 unselected writes ignored");
        desel('0); desel('0);
    endtask

    task automatic t_stall();
        ld_rd(8'h32, '0);
        chk(1'b0, '0, "R9 before stall");
        clk_en_n = 1'b1;
        issue_raw(LD, WR, 3'b001, 8'h32, 4'h0, 32'hCAFECAFE);
        chk(1'b0, '0, "R9 stall holds bus state");
        issue_raw(ADV, RD, 3'b001, 8'h00, 4'h0, 32'hCAFECAFE);
        chk(1'b0, '0, "R9 stall holds bus state 2");
        issue_raw(ADV, RD, 3'b001, 8'h00, 4'h0, 32'hCAFECAFE);
        clk_en_n = 1'b0;
        issue_raw(ADV, RD, 3'b001, 8'h99, 4'h0, '0);
        chk(1'b1, 32'hB0000032, "R9 read resumes after stall");
        desel('0);
        chk(1'b1, 32'hB0000033, "R9 burst address held during stall");
        desel('0);
        chk(1'b0, '0, "R9 bus floats after burst");
        ld_rd(8'h32, '0); desel('0);
        chk(1'b1, 32'hB0000032, "R9 stalled write not stored");
        desel('0); desel('0);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog: drive=%b data=%h expected drive=%b data=%h",
                 bus_drive, bus_out, 1'b0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_en_n = 1'b0; out_en_n = 1'b0;
        adv_not_ld = LD; rd_not_wr = RD; en_a_n = 1'b1; en_b_n = 1'b0; en_c = 1'b1;
        cmd_addr = '0; lane_wr_n = '1; bus_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_lanes();
        t_burst();
        t_interleave();
        t_deselect();
        t_out_enable();
        t_enables();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule